// File: doc/BRIEF.md
# Status Delta Event Latch

This block holds a bank of sticky event bits for a six-channel line monitor. Each channel owns two bits: a delta bit that latches whenever the channel's live status input changes value in either direction, and an error bit that latches a one-cycle error pulse. Once set, a bit stays set until software clears it. A masked OR of all latched bits produces one registered interrupt line.

Software reaches the bank through a simple synchronous register port with an address, a write strobe, a read strobe and registered read data. One global mode input sets how every event bit in the bank is cleared. In clear-on-read mode, a read of an event register clears all of its bits. In write-one-to-clear mode, reads have no effect and only written 1s clear bits. No channel has a clear control of its own.

Top module: `evt_latch_bank`

## Requirements
- R1: During and after a synchronous active-high reset, both event registers, both mask registers, `reg_rdata` and `irq` are 0. The status value present during reset is taken as the baseline, so it raises no delta.
- R2: The delta bit of channel i (address 0, bit i) sets in the cycle after `stat_in[i]` differs from its value on the previous clock. A rise and a fall both set it, and it stays set until it is cleared.
- R3: The error bit of channel i (address 1, bit i) sets in the cycle after `err_in[i]` is 1, and stays set until it is cleared.
- R4: With `clr_on_rd` = 1, a read of address 0 or address 1 returns the bits held before the read, on `reg_rdata` one cycle later, and clears every bit of that register. Writes to either event register are ignored in this mode.
- R5: With `clr_on_rd` = 0, reads leave the event registers unchanged. A write to an event register clears exactly the bits written as 1, and bits written as 0 keep their value.
- R6: If a delta or error event arrives in the same cycle as a clear of that bit, the bit ends up set.
- R7: `irq` is registered. It equals the OR over all bits of (delta & ~delta mask) | (error & ~error mask), taken from the register state one cycle earlier.
- R8: The delta mask (address 2) and error mask (address 3) are written whole and read back. Only bits 0..5 are stored. Upper data bits read 0, and the clear mode does not affect the masks.
- R9: A read of any address other than 0 to 3 returns 0. `reg_rdata` changes only on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_on_rd | input | 1 | Global clear mode: 1 clear-on-read, 0 write-one-to-clear |
| stat_in | input | 6 | Live status, one bit per channel |
| err_in | input | 6 | One-cycle error pulses, one bit per channel |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered interrupt |

## Verification
The clash that matters is an event and a clear of the same bit in one cycle. In clear-on-read mode this is a status flip applied during a read strobe. In write-one-to-clear mode it is an error pulse applied during a write of 1 to that bit. Directed cases check that the read returns the old contents and that the next read shows the new event still held. A long random phase then drives status, pulses, strobes and mode switches freely, which makes these collisions frequent, and a behavioural model in the bench judges `reg_rdata` and `irq` on every clock.

// File: rtl/evl_pkg.sv
package evl_pkg;
  localparam int ADR_DELTA = 0;
  localparam int ADR_ERR   = 1;
  localparam int ADR_DMASK = 2;
  localparam int ADR_EMASK = 3;
endpackage

// File: rtl/evl_delta_detect.sv
module evl_delta_detect #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    prev_q <= stat;
  end

  always_comb begin
    hit = rst ? '0 : (stat ^ prev_q);
  end
endmodule

// File: rtl/evl_sticky_bank.sv
module evl_sticky_bank #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] hit,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= (q[i] & ~clr[i]) | hit[i];
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      hit[i] |=> q[i]); // R6
    AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (q[i] && !clr[i]) |=> q[i]); // R2
    AST_BIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !hit[i]) |=> !q[i]); // R5
  end
endmodule

// File: rtl/evl_reg_port.sv
module evl_reg_port
  import evl_pkg::*;
#(
  parameter int NCH = 6,
  parameter int DW  = 8,
  parameter int AW  = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr_on_rd,
  input  logic [AW-1:0]  addr,
  input  logic           wr,
  input  logic           rd,
  input  logic [DW-1:0]  wdata,
  input  logic [NCH-1:0] dlt_q,
  input  logic [NCH-1:0] err_q,
  output logic [NCH-1:0] dlt_clr,
  output logic [NCH-1:0] err_clr,
  output logic [NCH-1:0] dmask,
  output logic [NCH-1:0] emask,
  output logic [DW-1:0]  rdata
);
  logic sel_d, sel_e, sel_dm, sel_em;
  logic [DW-1:0] rd_mux;

  always_comb begin
    sel_d  = (addr == AW'(ADR_DELTA));
    sel_e  = (addr == AW'(ADR_ERR));
    sel_dm = (addr == AW'(ADR_DMASK));
    sel_em = (addr == AW'(ADR_EMASK));
  end

  always_comb begin
    if (clr_on_rd) begin
      dlt_clr = {NCH{rd & sel_d}};
      err_clr = {NCH{rd & sel_e}};
    end else begin
      dlt_clr = (wr & sel_d) ? wdata[NCH-1:0] : '0;
      err_clr = (wr & sel_e) ? wdata[NCH-1:0] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dmask <= '0;
      emask <= '0;
    end else begin
      if (wr && sel_dm) dmask <= wdata[NCH-1:0];
      if (wr && sel_em) emask <= wdata[NCH-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_d)  rd_mux[NCH-1:0] = dlt_q;
    if (sel_e)  rd_mux[NCH-1:0] = err_q;
    if (sel_dm) rd_mux[NCH-1:0] = dmask;
    if (sel_em) rd_mux[NCH-1:0] = emask;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

  AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata)); // R9
  AST_MASK_KEPT: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ($stable(dmask) && $stable(emask))); // R8
endmodule

// File: rtl/evl_irq_merge.sv
module evl_irq_merge #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] dlt_q,
  input  logic [NCH-1:0] err_q,
  input  logic [NCH-1:0] dmask,
  input  logic [NCH-1:0] emask,
  output logic           irq
);
  logic pend;

  always_comb begin
    pend = |(dlt_q & ~dmask) | |(err_q & ~emask);
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= pend;
  end

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((dlt_q & ~dmask) == '0 && (err_q & ~emask) == '0) |=> !irq); // R7
  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (rst)
    ((dlt_q & ~dmask) != '0) |=> irq); // R7
endmodule

// File: rtl/evt_latch_bank.sv
module evt_latch_bank
  import evl_pkg::*;
#(
  parameter int NCH = 6,
  parameter int DW  = 8,
  parameter int AW  = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr_on_rd,
  input  logic [NCH-1:0] stat_in,
  input  logic [NCH-1:0] err_in,
  input  logic [AW-1:0]  reg_addr,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           irq
);
  logic [NCH-1:0] dlt_hit, err_hit;
  logic [NCH-1:0] dlt_clr, err_clr;
  logic [NCH-1:0] dlt_q, err_q;
  logic [NCH-1:0] dmask, emask;

  always_comb begin
    err_hit = rst ? '0 : err_in;
  end

  evl_delta_detect #(.W(NCH)) u_delta (
    .clk(clk), .rst(rst), .stat(stat_in), .hit(dlt_hit)
  );

  evl_sticky_bank #(.W(NCH)) u_dlt_bank (
    .clk(clk), .rst(rst), .hit(dlt_hit), .clr(dlt_clr), .q(dlt_q)
  );

  evl_sticky_bank #(.W(NCH)) u_err_bank (
    .clk(clk), .rst(rst), .hit(err_hit), .clr(err_clr), .q(err_q)
  );

  evl_reg_port #(.NCH(NCH), .DW(DW), .AW(AW)) u_port (
    .clk(clk), .rst(rst), .clr_on_rd(clr_on_rd),
    .addr(reg_addr), .wr(reg_wr), .rd(reg_rd), .wdata(reg_wdata),
    .dlt_q(dlt_q), .err_q(err_q),
    .dlt_clr(dlt_clr), .err_clr(err_clr),
    .dmask(dmask), .emask(emask), .rdata(reg_rdata)
  );

  evl_irq_merge #(.NCH(NCH)) u_irq (
    .clk(clk), .rst(rst), .dlt_q(dlt_q), .err_q(err_q),
    .dmask(dmask), .emask(emask), .irq(irq)
  );

  AST_COR_IGNORES_WR: assert property (@(posedge clk) disable iff (rst)
    (clr_on_rd && reg_wr && !reg_rd && reg_addr == AW'(ADR_DELTA))
      |=> (dlt_q == ($past(dlt_q) | $past(dlt_hit)))); // R4
  AST_W1C_IGNORES_RD: assert property (@(posedge clk) disable iff (rst)
    (!clr_on_rd && reg_rd && !reg_wr)
      |=> (err_q == ($past(err_q) | $past(err_hit)))); // R5
  AST_COR_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (clr_on_rd && reg_rd && reg_addr == AW'(ADR_ERR) && err_hit == '0)
      |=> (err_q == '0)); // R4
endmodule

// File: tb/evt_latch_bank_tb.sv
module evt_latch_bank_tb_top;
  localparam int NCH = 6;
  localparam int DW  = 8;
  localparam int AW  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cor = 1'b0;
  logic [NCH-1:0] stat = '0;
  logic [NCH-1:0] perr = '0;
  logic [AW-1:0]  addr = '0;
  logic wr = 1'b0;
  logic rd = 1'b0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] rdata;
  logic irq;

  always #4 clk = ~clk;

  evt_latch_bank #(.NCH(NCH), .DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .clr_on_rd(cor), .stat_in(stat), .err_in(perr),
    .reg_addr(addr), .reg_wr(wr), .reg_rd(rd), .reg_wdata(wd),
    .reg_rdata(rdata), .irq(irq)
  );

  int nvec = 0;
  int nfail = 0;
  string cur_req = "R1";
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp, string what);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  // behavioural reference model
  logic [NCH-1:0] m_d = '0, m_e = '0, m_dm = '0, m_em = '0, m_prev = '0;
  logic [DW-1:0]  m_rd = '0;
  logic           m_irq = 1'b0;

  always @(posedge clk) begin
    logic [NCH-1:0] cd, ce, hd;
    logic [DW-1:0] v;
    if (rst) begin
      m_d = '0; m_e = '0; m_dm = '0; m_em = '0; m_rd = '0; m_irq = 1'b0;
      m_prev = stat;
    end else begin
      hd = stat ^ m_prev;
      cd = '0; ce = '0;
      if (cor && rd) begin
        if (addr == 0) cd = '1;
        if (addr == 1) ce = '1;
      end
      if (!cor && wr) begin
        if (addr == 0) cd = wd[NCH-1:0];
        if (addr == 1) ce = wd[NCH-1:0];
      end
      m_irq = ((m_d & ~m_dm) != 0) || ((m_e & ~m_em) != 0);
      if (rd) begin
        case (addr)
          0: v = DW'(m_d);
          1: v = DW'(m_e);
          2: v = DW'(m_dm);
          3: v = DW'(m_em);
          default: v = '0;
        endcase
        m_rd = v;
      end
      if (wr && addr == 2) m_dm = wd[NCH-1:0];
      if (wr && addr == 3) m_em = wd[NCH-1:0];
      m_d = (m_d & ~cd) | hd;
      m_e = (m_e & ~ce) | perr;
      m_prev = stat;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(cur_req, 32'(rdata), 32'(m_rd), "rdata vs model");
      chk(cur_req, 32'(irq), 32'(m_irq), "irq vs model");
    end
  end

  task automatic rd_reg(logic [AW-1:0] a, logic [DW-1:0] exp, string req);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk(req, 32'(rdata), 32'(exp), "read");
  endtask

  task automatic wr_reg(logic [AW-1:0] a, logic [DW-1:0] d);
    addr = a; wd = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic set_stat(logic [NCH-1:0] s);
    stat = s;
    @(negedge clk);
  endtask

  task automatic pulse(logic [NCH-1:0] p);
    perr = p;
    @(negedge clk);
    perr = '0;
  endtask

  function automatic void summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nvec++; nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    stat = 6'h2A;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_en = 1'b1;

    cur_req = "R1";
    chk("R1", 32'(irq), 0, "irq after reset");
    rd_reg(0, 8'h00, "R1");
    rd_reg(1, 8'h00, "R1");
    rd_reg(2, 8'h00, "R1");
    rd_reg(3, 8'h00, "R1");

    cur_req = "R2";
    set_stat(6'h2B);
    set_stat(6'h29);
    rd_reg(0, 8'h03, "R2");
    rd_reg(0, 8'h03, "R5");

    cur_req = "R5";
    wr_reg(0, 8'h02);
    rd_reg(0, 8'h01, "R5");
    wr_reg(0, 8'h00);
    rd_reg(0, 8'h01, "R5");
    wr_reg(0, 8'h01);
    rd_reg(0, 8'h00, "R5");

    cur_req = "R3";
    pulse(6'h24);
    repeat (3) @(negedge clk);
    rd_reg(1, 8'h24, "R3");

    cur_req = "R7";
    chk("R7", 32'(irq), 1, "irq with unmasked error");
    wr_reg(3, 8'h24);
    @(negedge clk);
    chk("R7", 32'(irq), 0, "irq fully masked");
    rd_reg(3, 8'h24, "R8");
    wr_reg(3, 8'h04);
    @(negedge clk);
    chk("R7", 32'(irq), 1, "irq partly masked");
    wr_reg(3, 8'h00);
    wr_reg(1, 8'h24);
    rd_reg(1, 8'h00, "R5");

    cur_req = "R4";
    cor = 1'b1;
    set_stat(6'h39);
    wr_reg(0, 8'hFF);
    rd_reg(0, 8'h10, "R4");
    rd_reg(0, 8'h00, "R4");
    pulse(6'h01);
    rd_reg(1, 8'h01, "R4");
    rd_reg(1, 8'h00, "R4");

    cur_req = "R6";
    set_stat(6'h3D);
    addr = 0; rd = 1'b1; stat = 6'h35;
    @(negedge clk);
    rd = 1'b0;
    chk("R6", 32'(rdata), 32'h04, "read during status flip");
    rd_reg(0, 8'h08, "R6");
    cor = 1'b0;
    addr = 1; wd = 8'h01; wr = 1'b1; perr = 6'h01;
    @(negedge clk);
    wr = 1'b0; perr = '0;
    rd_reg(1, 8'h01, "R6");

    cur_req = "R8";
    wr_reg(2, 8'hFF);
    rd_reg(2, 8'h3F, "R8");
    cor = 1'b1;
    rd_reg(2, 8'h3F, "R8");
    cor = 1'b0;
    wr_reg(2, 8'h00);

    cur_req = "R9";
    rd_reg(5, 8'h00, "R9");
    @(negedge clk);
    chk("R9", 32'(rdata), 0, "rdata held without read");

    cur_req = "R6";
    for (int k = 0; k < 4000; k++) begin
      if (($urandom % 4) == 0) stat = NCH'($urandom);
      perr = (($urandom % 3) == 0) ? NCH'($urandom) : '0;
      addr = AW'($urandom % 6);
      wd = DW'($urandom);
      rd = (($urandom % 3) == 0);
      wr = (($urandom % 3) == 0);
      if (($urandom % 50) == 0) cor = ~cor;
      @(negedge clk);
    end
    rd = 1'b0; wr = 1'b0; perr = '0;
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule